// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes up to 24 interrupt input lines to interrupt messages. Every line owns a 64-bit redirection entry holding a vector, a trigger kind, a mask, a destination mode, a delivery mode and an 8-bit destination. Input lines are not sampled as levels. A source reports assert, deassert or pulse events against a line number, and the block keeps a signed assertion count for each line. A message goes out when the count moves from zero to one. It also goes out again after an entry update or after an end-of-interrupt notice, as long as the line is still held.

Software reaches the block through a small register port with two locations. One location holds an index and the other is a data window onto the register that the index selects. Messages leave on a valid/ready port that carries vector, destination, a level flag and a broadcast flag. End-of-interrupt notices arrive as a one-cycle strobe carrying a vector. When several lines wait to send, the lowest-numbered line is offered first.

Top module: `ioredir_ctrl`

## Requirements
- R1: After reset no message is offered, every assertion count is zero, and every entry reads 0x0001_0000 in its low half (masked) and 0 in its high half.
- R2: Port address 0x00 holds the 8-bit index and address 0x10 is the data window. Window index 0x01 reads ((NUM_PINS-1) << 16) | 0x11. Index 0x00 holds a 4-bit controller ID in bits 27:24. Index 0x02 reads the same ID. Writes to 0x01 and 0x02 have no effect.
- R3: Event op 0 adds one to a line's count and op 1 subtracts one. Both saturate at the signed limits of the count (+7 and -8 by default). Only an assert that finds the count at exactly zero requests a message. Every other transition requests nothing, including 1 to 0 and any change below zero.
- R4: Event op 2 (pulse) requests a message when the count is zero and leaves the count unchanged.
- R5: A request produces no message when the entry is masked (bit 16 = 1), when the destination mode is logical (bit 11 = 1), or when the delivery mode (bits 10:8) is not 000.
- R6: A delivered request on a level entry (bit 15 = 1) sets remote-IRR (bit 14) and gives msg_level = 1. An edge entry gives msg_level = 0 and leaves remote-IRR unchanged.
- R7: msg_vector is entry bits 7:0 and msg_dest is bits 63:56. msg_bcast is 1 exactly when the destination is 0xFF.
- R8: Window index 0x10+2p writes bits 31:0 of line p's entry and 0x11+2p writes bits 63:32. Written values of bits 12 and 14 are discarded. Unused indices read 0 and ignore writes.
- R9: An entry write requests a message when the new entry is unmasked, remote-IRR is clear and the count is above zero.
- R10: An EOI clears remote-IRR on every line whose remote-IRR is set and whose vector equals the EOI vector. Each such line with a count above zero requests a message again.
- R11: A delivered request leaves the line waiting until msg_ready is seen with msg_valid. Bit 12 reads 1 while the line waits. The lowest-numbered waiting line is offered. Requests made while a line already waits merge into one message.
- R12: When an EOI and an entry write hit the same line in one cycle, the EOI is applied first and the write sees the cleared remote-IRR. All checks in a cycle use the count as it stood at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Line event strobe |
| ev_pin | input | 5 | Line number of the event; values of NUM_PINS and above are ignored |
| ev_op | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 ignored |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 8 | 0x00 index, 0x10 data window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the offered message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Destination ID |
| msg_level | output | 1 | Message comes from a level entry |
| msg_bcast | output | 1 | Destination is all targets |

## Verification
An EOI and an entry write can both act on the same line in one cycle. Each can clear or consult remote-IRR, and each can request a message. The bench provokes this with directed cycles that retire a level line's vector while the same line's entry is written, once masked and once unmasked. It expects no message and remote-IRR clear in the first case, and exactly one message in the second. Random cycles then mix events, window writes and EOIs in the same cycle and compare every output against a bench model that applies the EOI before the write.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

  typedef enum logic [1:0] {
    EV_ASSERT   = 2'd0,
    EV_DEASSERT = 2'd1,
    EV_PULSE    = 2'd2,
    EV_NONE     = 2'd3
  } ev_op_e;

  // entry field positions (guest-visible layout)
  localparam int F_VEC_LSB  = 0;
  localparam int F_VEC_W    = 8;
  localparam int F_DLV_LO   = 8;
  localparam int F_DLV_HI   = 10;
  localparam int F_DMODE    = 11;
  localparam int F_DSTAT    = 12;
  localparam int F_RIRR     = 14;
  localparam int F_TRIG     = 15;
  localparam int F_MASK     = 16;
  localparam int F_DEST_LSB = 56;
  localparam int F_DEST_W   = 8;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/ioredir_pin.sv
module ioredir_pin
  import ioredir_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_hit,
  input  ev_op_e      ev_op,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        eoi_stb,
  input  logic [7:0]  eoi_vec,
  input  logic        grant,
  output logic [63:0] entry_o,
  output logic        pend_o
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic [63:0]             ent_q, ent_d;
  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic                    rirr_q, rirr_d, pend_q, pend_d;
  logic                    ent_en, cnt_pos, cnt_zero;
  logic                    eoi_match, rirr_mid, ev_trig, wr_trig, trig, send;

  // entry next value: read-only bits are never stored
  always_comb begin
    ent_d = ent_q;
    if (wr_lo) ent_d[31:0]  = wdata;
    if (wr_hi) ent_d[63:32] = wdata;
    ent_d[F_DSTAT] = 1'b0;
    ent_d[F_RIRR]  = 1'b0;
  end
  assign ent_en = wr_lo | wr_hi;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_pos  = !cnt_q[CNT_W-1] && !cnt_zero;

  // EOI retires first, then the write looks at remote-IRR
  assign eoi_match = eoi_stb && rirr_q && (ent_q[F_VEC_LSB +: F_VEC_W] == eoi_vec);
  assign rirr_mid  = rirr_q && !eoi_match;
  assign ev_trig   = ev_hit && ((ev_op == EV_ASSERT) || (ev_op == EV_PULSE)) && cnt_zero;
  assign wr_trig   = ent_en && !ent_d[F_MASK] && !rirr_mid && cnt_pos;
  assign trig      = ev_trig || wr_trig || (eoi_match && cnt_pos);
  assign send      = trig && !ent_d[F_MASK] && !ent_d[F_DMODE] &&
                     (ent_d[F_DLV_HI:F_DLV_LO] == 3'b000);

  assign rirr_d = rirr_mid || (send && ent_d[F_TRIG]);
  assign pend_d = (pend_q && !grant) || send;

  always_comb begin
    cnt_d = cnt_q;
    if (ev_hit) begin
      case (ev_op)
        EV_ASSERT:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        EV_DEASSERT: if (cnt_q != CNT_MIN) cnt_d = cnt_q - CNT_W'(1);
        default:     cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q  <= ENTRY_RST;
      cnt_q  <= '0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ent_en) ent_q <= ent_d;
      if (ev_hit) cnt_q <= cnt_d;
      rirr_q <= rirr_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    entry_o          = ent_q;
    entry_o[F_DSTAT] = pend_q;
    entry_o[F_RIRR]  = rirr_q;
  end
  assign pend_o = pend_q;

  AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    send && ent_d[F_TRIG] |=> rirr_q); // R6
  AST_RIRR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_q && !eoi_stb |=> rirr_q); // R10
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit |=> $stable(cnt_q)); // R3
  AST_PULSE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && (ev_op == EV_PULSE) |=> $stable(cnt_q)); // R4
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ent_q[F_MASK] && !ent_en |=> !$rose(pend_q)); // R5
  AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(trig)); // R9

endmodule

// File: rtl/ioredir_pick.sv
module ioredir_pick #(
  parameter int N     = 24,
  parameter int SEL_W = 5
) (
  input  logic [N-1:0]     req,
  input  logic             ready,
  output logic             valid,
  output logic [SEL_W-1:0] sel,
  output logic [N-1:0]     grant
);

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) sel = SEL_W'(i);
    end
    valid = |req;
    grant = '0;
    if (valid && ready) grant[sel] = 1'b1;
  end

endmodule

// File: rtl/ioredir_ctrl.sv
module ioredir_ctrl
  import ioredir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int CNT_W    = 4,
  parameter int ID_W     = 4,
  parameter int ID_LSB   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [4:0]  ev_pin,
  input  logic [1:0]  ev_op,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eoi_valid,
  input  logic [7:0]  eoi_vector,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [7:0]  msg_vector,
  output logic [7:0]  msg_dest,
  output logic        msg_level,
  output logic        msg_bcast
);

  localparam int          SEL_W    = $clog2(NUM_PINS);
  localparam int          IDX_W    = 8;
  localparam int          ENT_BASE = 16;
  localparam logic [7:0]  ADDR_SEL = 8'h00;
  localparam logic [7:0]  ADDR_WIN = 8'h10;
  localparam logic [31:0] VERSION  = (32'(NUM_PINS - 1) << 16) | 32'h11;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             sel_wr, win_wr, id_wr;
  ev_op_e           op_c;

  assign sel_wr = reg_wr && (reg_addr == ADDR_SEL);
  assign win_wr = reg_wr && (reg_addr == ADDR_WIN);
  assign id_wr  = win_wr && (idx_q == '0);
  assign idx_d  = reg_wdata[IDX_W-1:0];
  assign id_d   = reg_wdata[ID_LSB +: ID_W];
  assign op_c   = ev_op_e'(ev_op);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      idx_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) idx_q <= idx_d;
      if (id_wr)  id_q  <= id_d;
    end
  end

  logic [63:0]         ent_all [NUM_PINS];
  logic [NUM_PINS-1:0] pend, grant;
  logic [SEL_W-1:0]    sel;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(ENT_BASE + 2 * p);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(ENT_BASE + 2 * p + 1);
    logic hit;
    assign hit = ev_valid && (ev_pin == SEL_W'(p));
    ioredir_pin #(.CNT_W(CNT_W)) u_pin (
      .clk     (clk),
      .rst_n   (rst_s),
      .ev_hit  (hit),
      .ev_op   (op_c),
      .wr_lo   (win_wr && (idx_q == LO_IDX)),
      .wr_hi   (win_wr && (idx_q == HI_IDX)),
      .wdata   (reg_wdata),
      .eoi_stb (eoi_valid),
      .eoi_vec (eoi_vector),
      .grant   (grant[p]),
      .entry_o (ent_all[p]),
      .pend_o  (pend[p])
    );
  end

  ioredir_pick #(.N(NUM_PINS), .SEL_W(SEL_W)) u_pick (
    .req   (pend),
    .ready (msg_ready),
    .valid (msg_valid),
    .sel   (sel),
    .grant (grant)
  );

  assign msg_vector = ent_all[sel][F_VEC_LSB +: F_VEC_W];
  assign msg_dest   = ent_all[sel][F_DEST_LSB +: F_DEST_W];
  assign msg_level  = ent_all[sel][F_TRIG];
  assign msg_bcast  = (msg_dest == 8'hFF);

  logic [31:0] win_rd;
  always_comb begin
    win_rd = '0;
    if (idx_q == 8'h00 || idx_q == 8'h02) win_rd = 32'(id_q) << ID_LSB;
    if (idx_q == 8'h01) win_rd = VERSION;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (idx_q == IDX_W'(ENT_BASE + 2 * p))     win_rd = ent_all[p][31:0];
      if (idx_q == IDX_W'(ENT_BASE + 2 * p + 1)) win_rd = ent_all[p][63:32];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_SEL) reg_rdata = 32'(idx_q);
    if (reg_addr == ADDR_WIN) reg_rdata = win_rd;
  end

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    msg_valid && !msg_ready |=> msg_valid); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(grant)); // R11
  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_s)
    !msg_ready |-> (grant == '0)); // R11

endmodule

// File: tb/ioredir_ctrl_test.sv
`timescale 1ns/1ps
module ioredir_ctrl_test;

  localparam int N = 24;

  logic        clk, rst_n;
  logic        ev_valid;
  logic [4:0]  ev_pin;
  logic [1:0]  ev_op;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eoi_valid;
  logic [7:0]  eoi_vector;
  logic        msg_valid, msg_ready, msg_level, msg_bcast;
  logic [7:0]  msg_vector, msg_dest;

  ioredir_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_op(ev_op),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_level(msg_level), .msg_bcast(msg_bcast)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [63:0] m_ent [N];
  int          m_cnt [N];
  bit          m_rirr [N];
  bit          m_pend [N];
  logic [7:0]  m_idx;
  logic [3:0]  m_id;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_win();
    logic [31:0] v = '0;
    if (m_idx == 8'h00 || m_idx == 8'h02) v = {4'b0, m_id, 24'b0};
    if (m_idx == 8'h01) v = 32'h0017_0011;
    for (int p = 0; p < N; p++) begin
      if (m_idx == 8'(16 + 2 * p))
        v = m_ent[p][31:0] | (32'(m_pend[p]) << 12) | (32'(m_rirr[p]) << 14);
      if (m_idx == 8'(17 + 2 * p)) v = m_ent[p][63:32];
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    if (reg_addr == 8'h00) return 32'(m_idx);
    if (reg_addr == 8'h10) return exp_win();
    return 32'h0;
  endfunction

  function automatic int low_pend();
    for (int p = 0; p < N; p++) if (m_pend[p]) return p;
    return -1;
  endfunction

  task automatic model_step();
    int sel = low_pend();
    for (int p = 0; p < N; p++) begin
      logic [63:0] nd = m_ent[p];
      bit wl = reg_wr && reg_addr == 8'h10 && m_idx == 8'(16 + 2 * p);
      bit wh = reg_wr && reg_addr == 8'h10 && m_idx == 8'(17 + 2 * p);
      bit hit = ev_valid && (int'(ev_pin) == p);
      bit eclr, rmid, trig, ok;
      if (wl) nd[31:0] = reg_wdata;
      if (wh) nd[63:32] = reg_wdata;
      nd[12] = 1'b0; nd[14] = 1'b0;
      eclr = eoi_valid && m_rirr[p] && (m_ent[p][7:0] == eoi_vector);
      rmid = m_rirr[p] && !eclr;
      trig = (hit && (ev_op == 2'd0 || ev_op == 2'd2) && m_cnt[p] == 0) ||
             ((wl || wh) && !nd[16] && !rmid && m_cnt[p] > 0) ||
             (eclr && m_cnt[p] > 0);
      ok = trig && !nd[11] && nd[10:8] == 3'b000 && !nd[16];
      m_pend[p] = (m_pend[p] && !(msg_ready && sel == p)) || ok;
      m_rirr[p] = rmid || (ok && nd[15]);
      m_ent[p]  = nd;
      if (hit && ev_op == 2'd0 && m_cnt[p] < 7)  m_cnt[p]++;
      if (hit && ev_op == 2'd1 && m_cnt[p] > -8) m_cnt[p]--;
    end
    if (reg_wr && reg_addr == 8'h10 && m_idx == 8'h00) m_id = reg_wdata[27:24];
    if (reg_wr && reg_addr == 8'h00) m_idx = reg_wdata[7:0];
  endtask

  // one cycle: compare outputs with model, advance model, clear strobes
  task automatic tick();
    int s;
    #0.5;
    s = low_pend();
    chk("R11 msg_valid", msg_valid, s >= 0);
    if (s >= 0 && msg_valid) begin
      chk("R7 vector", msg_vector, m_ent[s][7:0]);
      chk("R7 dest", msg_dest, m_ent[s][63:56]);
      chk("R6 level", msg_level, m_ent[s][15]);
      chk("R7 bcast", msg_bcast, m_ent[s][63:56] == 8'hFF);
    end
    chk("R8 rdata", reg_rdata, exp_rd());
    model_step();
    @(negedge clk);
    ev_valid = 0; reg_wr = 0; eoi_valid = 0;
  endtask

  task automatic set_idx(logic [7:0] i);
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'(i); tick(); reg_addr = 8'h10;
  endtask
  task automatic wr_win(logic [31:0] d);
    reg_wr = 1; reg_addr = 8'h10; reg_wdata = d; tick();
  endtask
  task automatic wr_reg(logic [7:0] i, logic [31:0] d);
    set_idx(i); wr_win(d);
  endtask
  task automatic rd(logic [7:0] i, output logic [31:0] v);
    set_idx(i); #0.5 v = reg_rdata;
  endtask
  task automatic ev(int p, int op);
    ev_valid = 1; ev_pin = 5'(p); ev_op = 2'(op); tick();
  endtask
  task automatic eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vector = v; tick();
  endtask
  task automatic accept();
    msg_ready = 1; tick(); msg_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] rnd_lo();
    logic [31:0] r = $urandom;
    logic [7:0] vl [5] = '{8'h30, 8'h41, 8'h22, 8'h77, 8'h23};
    logic [31:0] d = 32'(vl[$urandom % 5]);
    d[15] = r[0];
    d[16] = (r[3:1] == 0);
    d[11] = (r[6:4] == 0);
    if (r[9:7] == 0) d[10:8] = r[12:10] | 3'b001;
    d[12] = r[13]; d[14] = r[14]; d[13] = r[15];
    return d;
  endfunction

  initial begin
    logic [31:0] v;
    int pl [5] = '{2, 3, 5, 7, 23};
    void'($urandom(32'd20240611));
    rst_n = 0; ev_valid = 0; ev_pin = 0; ev_op = 0; reg_wr = 0; reg_addr = 8'h10;
    reg_wdata = 0; eoi_valid = 0; eoi_vector = 0; msg_ready = 0;
    for (int p = 0; p < N; p++) begin
      m_ent[p] = 64'h0001_0000; m_cnt[p] = 0; m_rirr[p] = 0; m_pend[p] = 0;
    end
    m_idx = 0; m_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, R2 identification registers
    chk("R1 no message after reset", msg_valid, 0);
    rd(8'h10, v); chk("R1 entry 0 low", v, 32'h0001_0000);
    rd(8'h3F, v); chk("R1 entry 23 high", v, 0);
    rd(8'h01, v); chk("R2 version", v, 32'h0017_0011);
    wr_reg(8'h00, 32'h0A00_0000);
    rd(8'h00, v); chk("R2 id", v, 32'h0A00_0000);
    rd(8'h02, v); chk("R2 arbitration id", v, 32'h0A00_0000);
    wr_reg(8'h01, 32'hFFFF_FFFF);
    rd(8'h01, v); chk("R2 version read-only", v, 32'h0017_0011);

    // R3 counting, R7 unicast fields
    wr_reg(8'h17, 32'h0500_0000);
    wr_reg(8'h16, 32'h0000_0030);
    chk("R9 write with zero count", msg_valid, 0);
    ev(3, 0);
    chk("R3 first assert sends", msg_valid, 1);
    chk("R7 vector", msg_vector, 8'h30);
    chk("R7 dest", msg_dest, 8'h05);
    chk("R6 edge level flag", msg_level, 0);
    chk("R7 unicast", msg_bcast, 0);
    rd(8'h16, v); chk("R11 delivery status while waiting", v, 32'h0000_1030);
    accept();
    chk("R11 taken", msg_valid, 0);
    ev(3, 0); chk("R3 second assert silent", msg_valid, 0);
    ev(3, 1); ev(3, 1); ev(3, 1); ev(3, 0);
    chk("R3 back to zero from below silent", msg_valid, 0);
    ev(3, 0); chk("R3 zero to one sends", msg_valid, 1);
    accept(); ev(3, 1);

    // R4 pulse
    ev(3, 2); chk("R4 pulse sends", msg_valid, 1);
    accept();
    wr_reg(8'h16, 32'h0000_0030);
    chk("R4 pulse leaves count at zero", msg_valid, 0);

    // R5 suppression, R9 write redelivery
    wr_reg(8'h16, 32'h0001_0030);
    ev(3, 0); chk("R5 masked", msg_valid, 0);
    wr_reg(8'h16, 32'h0000_0030); chk("R9 unmask sends", msg_valid, 1);
    accept();
    wr_reg(8'h16, 32'h0000_0830); chk("R5 logical mode", msg_valid, 0);
    wr_reg(8'h16, 32'h0000_0130); chk("R5 delivery mode", msg_valid, 0);
    ev(3, 1);
    wr_reg(8'h16, 32'h0000_0030);

    // R6 level, R10 EOI, R8 read-only bits
    wr_reg(8'h1B, 32'hFF00_0000);
    wr_reg(8'h1A, 32'h0000_8041);
    ev(5, 0);
    chk("R6 level flag", msg_level, 1);
    chk("R7 broadcast", msg_bcast, 1);
    chk("R7 broadcast dest", msg_dest, 8'hFF);
    rd(8'h1A, v); chk("R6 remote-IRR set", v, 32'h0000_D041);
    accept();
    rd(8'h1A, v); chk("R6 remote-IRR after accept", v, 32'h0000_C041);
    wr_win(32'h0000_8041); chk("R9 remote-IRR blocks", msg_valid, 0);
    wr_win(32'h0000_9041);
    rd(8'h1A, v); chk("R8 status bits kept", v, 32'h0000_C041);
    eoi(8'h40);
    rd(8'h1A, v); chk("R10 other vector keeps remote-IRR", v, 32'h0000_C041);
    eoi(8'h41); chk("R10 EOI with count resends", msg_valid, 1);
    accept(); ev(5, 1);
    eoi(8'h41); chk("R10 EOI with zero count silent", msg_valid, 0);
    rd(8'h1A, v); chk("R10 remote-IRR cleared", v, 32'h0000_8041);
    wr_win(32'h0000_C041);
    rd(8'h1A, v); chk("R8 remote-IRR not writable", v, 32'h0000_8041);

    // R12 EOI and write on one line in one cycle
    ev(5, 0); accept();
    set_idx(8'h1A);
    eoi_valid = 1; eoi_vector = 8'h41; reg_wr = 1; reg_wdata = 32'h0001_8041; tick();
    chk("R12 masked write with EOI", msg_valid, 0);
    rd(8'h1A, v); chk("R12 remote-IRR cleared", v, 32'h0001_8041);
    wr_win(32'h0000_8041); accept();
    eoi_valid = 1; eoi_vector = 8'h41; reg_wr = 1; reg_wdata = 32'h0000_8041; tick();
    chk("R12 one message", msg_valid, 1);
    accept(); chk("R12 only one", msg_valid, 0);
    rd(8'h1A, v); chk("R12 remote-IRR set again", v, 32'h0000_C041);
    ev(5, 1); eoi(8'h41);

    // R11 priority and merge
    wr_reg(8'h1E, 32'h0000_0077);
    wr_reg(8'h14, 32'h0000_0022);
    ev(7, 0); chk("R11 single", msg_vector, 8'h77);
    ev(2, 0); chk("R11 lower line first", msg_vector, 8'h22);
    accept(); chk("R11 next line", msg_vector, 8'h77);
    accept(); chk("R11 drained", msg_valid, 0);
    wr_win(32'h0000_0022); wr_win(32'h0000_0022);
    chk("R11 merged", msg_vector, 8'h22);
    accept(); chk("R11 merged into one", msg_valid, 0);
    ev(2, 1); ev(7, 1);

    // R3 saturation on last line
    for (int k = 0; k < 9; k++) ev(23, 0);
    for (int k = 0; k < 7; k++) ev(23, 1);
    wr_reg(8'h3E, 32'h0000_0023);
    chk("R3 saturated count back to zero", msg_valid, 0);
    ev(23, 0); chk("R3 assert after saturation", msg_vector, 8'h23);
    accept(); ev(23, 1);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom % 100;
      if (r < 40) begin
        ev_valid = 1;
        ev_pin = (($urandom % 10) == 0) ? 5'(24 + $urandom % 8) : 5'(pl[$urandom % 5]);
        ev_op = 2'($urandom % 4);
      end
      r = $urandom % 100;
      if (r < 15) begin
        reg_wr = 1; reg_addr = 8'h00;
        case ($urandom % 4)
          0: reg_wdata = 32'($urandom % 3);
          1: reg_wdata = 32'h40;
          default: reg_wdata = 32'(16 + 2 * pl[$urandom % 5] + ($urandom % 2));
        endcase
      end else if (r < 35) begin
        reg_wr = 1; reg_addr = 8'h10;
        if (m_idx[0]) reg_wdata = {(($urandom % 3 == 0) ? 8'hFF : 8'($urandom)), 24'($urandom)};
        else reg_wdata = rnd_lo();
      end else if (r < 40) begin
        reg_wr = 1; reg_addr = 8'($urandom); reg_wdata = $urandom;
      end else begin
        reg_addr = (($urandom % 4) == 0) ? 8'h00 : 8'h10;
      end
      if (($urandom % 100) < 20) begin
        eoi_valid = 1;
        eoi_vector = (($urandom % 2) == 0) ? 8'h41 : 8'($urandom % 128);
      end
      msg_ready = (($urandom % 100) < 60);
      tick();
    end
    msg_ready = 0;
    finish_run();
  end

endmodule